// File: doc/BRIEF.md
# Memory-Map Glue Decoder for an 8-bit Processor

This block sits next to an 8-bit microprocessor with a 16-bit address bus. From the upper address lines (A15 down to A5), the read/write line and the phase-2 clock, it produces every active-low strobe that a small system needs. These are a RAM chip select, a ROM chip select, one write enable shared by all writable devices, separate output enables for RAM and ROM, and eight select lines for peripherals in a single I/O page.

The map has three regions. RAM fills the low 48 KiB. ROM covers the rest of the space except one 256-byte page, $FE00–$FEFF. That page is taken out of ROM for I/O, and the top page stays in ROM so that the vectors can be fetched. Address bits A7–A5 split the I/O page into eight 32-byte blocks. The chip selects depend on the address only, so a device is already selected while the address settles during clock-low. The read and write strobes open only while phase-2 is high.

All logic is combinational. The address lines A4–A0 do not reach the block, so a decode cannot depend on them. The block has no data stream, so every pin is a plain level signal with no valid/ready handshake.

Top module: `mem_glue_decoder`

## Requirements
- R1: `ram_cs_n` is low exactly when the address high byte (`addr_hi[10:3]`, which is A15–A8) is in 0x00–0xBF.
- R2: `rom_cs_n` is low exactly when the high byte is in 0xC0–0xFD or equals 0xFF.
- R3: When the high byte is 0xFE, neither `ram_cs_n` nor `rom_cs_n` is low. For every address, exactly one region is active: RAM, ROM, or I/O (any `io_sel_n` bit low).
- R4: `we_n` is low exactly when `phi2` is 1 and `rw` is 0 (rw = 1 means read, rw = 0 means write).
- R5: `ram_oe_n` is low exactly when `phi2` is 1, `rw` is 1 and the address is in the RAM region.
- R6: `rom_oe_n` is low exactly when `phi2` is 1, `rw` is 1 and the address is in the ROM region. In particular, it stays high during every write.
- R7: `ram_cs_n`, `rom_cs_n` and `io_sel_n` depend on the address only. They take the same value for all four combinations of `phi2` and `rw`.
- R8: `io_sel_n[k]` is low exactly when the high byte is 0xFE and A7–A5 (`addr_hi[2:0]`) equal k. At most one bit of `io_sel_n` is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_hi | input | 11 | Address bits A15..A5 (bit 10 = A15) |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| phi2 | input | 1 | Phase-2 clock level |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| we_n | output | 1 | Shared write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| io_sel_n | output | 8 | I/O block selects, active low, bit k for A7..A5 = k |

## Verification
The bench sweeps all 256 high-byte values. For each one it applies all eight A7–A5 codes and all four combinations of `phi2` and `rw`. Holding the address fixed while only the phase and direction change separates the address-only chip selects from the clock-gated strobes (R7). The same sweep also catches a ROM enable that stays open during writes. Directed patterns at the edges 0xBF/0xC0 and 0xFD/0xFE/0xFF distinguish an off-by-one page compare from a correct one. Walking A7–A5 across the I/O page, and across pages next to it, confirms that the one-hot block selects appear only in page 0xFE.

// File: rtl/glue_pkg.sv
package glue_pkg;

  // Memory regions a decoded address can fall in.
  typedef enum logic [1:0] {
    REGION_RAM = 2'd0,
    REGION_ROM = 2'd1,
    REGION_IO  = 2'd2
  } region_e;

  // Default map constants.
  localparam int unsigned ADDR_HI_W_DEF     = 11;
  localparam int unsigned PAGE_W_DEF        = 8;
  localparam int unsigned RAM_LAST_PAGE_DEF = 'hBF;
  localparam int unsigned IO_PAGE_DEF       = 'hFE;

endpackage

// File: rtl/glue_region_dec.sv
module glue_region_dec
  import glue_pkg::*;
#(
  parameter int unsigned PAGE_W        = PAGE_W_DEF,
  parameter int unsigned RAM_LAST_PAGE = RAM_LAST_PAGE_DEF,
  parameter int unsigned IO_PAGE       = IO_PAGE_DEF
) (
  input  logic [PAGE_W-1:0] page,
  output region_e           region,
  output logic              in_ram,
  output logic              in_rom,
  output logic              in_io
);

  localparam logic [PAGE_W-1:0] RAM_LAST = PAGE_W'(RAM_LAST_PAGE);
  localparam logic [PAGE_W-1:0] IO_PG    = PAGE_W'(IO_PAGE);

  always_comb begin
    if (page == IO_PG) begin
      region = REGION_IO;
    end else if (page <= RAM_LAST) begin
      region = REGION_RAM;
    end else begin
      region = REGION_ROM;
    end
  end

  assign in_ram = (region == REGION_RAM);
  assign in_rom = (region == REGION_ROM);
  assign in_io  = (region == REGION_IO);

endmodule

// File: rtl/glue_strobe_gen.sv
module glue_strobe_gen (
  input  logic phi2,
  input  logic rw,
  output logic rd_phase,
  output logic wr_phase
);

  // Direction-qualified strobes, open only while phase-2 is high.
  assign rd_phase = phi2 &  rw;
  assign wr_phase = phi2 & ~rw;

endmodule

// File: rtl/glue_io_subdec.sv
module glue_io_subdec #(
  parameter int unsigned SUB_W = 3,
  localparam int unsigned BLOCKS = 1 << SUB_W
) (
  input  logic              page_hit,
  input  logic [SUB_W-1:0]  sub,
  output logic [BLOCKS-1:0] sel_n
);

  for (genvar g = 0; g < BLOCKS; g++) begin : g_blk
    localparam logic [SUB_W-1:0] CODE = SUB_W'(g);
    assign sel_n[g] = ~(page_hit && (sub == CODE));
  end

endmodule

// File: rtl/mem_glue_decoder.sv
module mem_glue_decoder
  import glue_pkg::*;
#(
  parameter int unsigned ADDR_HI_W     = ADDR_HI_W_DEF,
  parameter int unsigned PAGE_W        = PAGE_W_DEF,
  parameter int unsigned RAM_LAST_PAGE = RAM_LAST_PAGE_DEF,
  parameter int unsigned IO_PAGE       = IO_PAGE_DEF,
  localparam int unsigned SUB_W        = ADDR_HI_W - PAGE_W,
  localparam int unsigned IO_BLOCKS    = 1 << SUB_W
) (
  input  logic [ADDR_HI_W-1:0] addr_hi,
  input  logic                 rw,
  input  logic                 phi2,
  output logic                 ram_cs_n,
  output logic                 rom_cs_n,
  output logic                 we_n,
  output logic                 ram_oe_n,
  output logic                 rom_oe_n,
  output logic [IO_BLOCKS-1:0] io_sel_n
);

  logic [PAGE_W-1:0] page;
  logic [SUB_W-1:0]  sub;
  region_e           region;
  logic              in_ram, in_rom, in_io;
  logic              rd_phase, wr_phase;

  assign page = addr_hi[ADDR_HI_W-1:SUB_W];
  assign sub  = addr_hi[SUB_W-1:0];

  glue_region_dec #(
    .PAGE_W       (PAGE_W),
    .RAM_LAST_PAGE(RAM_LAST_PAGE),
    .IO_PAGE      (IO_PAGE)
  ) u_region (
    .page  (page),
    .region(region),
    .in_ram(in_ram),
    .in_rom(in_rom),
    .in_io (in_io)
  );

  glue_strobe_gen u_strobe (
    .phi2    (phi2),
    .rw      (rw),
    .rd_phase(rd_phase),
    .wr_phase(wr_phase)
  );

  glue_io_subdec #(.SUB_W(SUB_W)) u_io (
    .page_hit(in_io),
    .sub     (sub),
    .sel_n   (io_sel_n)
  );

  // Address-only chip selects.
  assign ram_cs_n = ~in_ram;
  assign rom_cs_n = ~in_rom;

  // Clock-phase strobes; each enable is one AND level from the inputs.
  assign we_n     = ~wr_phase;
  assign ram_oe_n = ~(rd_phase & in_ram);
  assign rom_oe_n = ~(rd_phase & in_rom);

  logic unused_region;
  assign unused_region = ^region;

endmodule

// File: rtl/glue_decoder_chk.sv
module glue_decoder_chk #(
  parameter int unsigned ADDR_HI_W = 11,
  parameter int unsigned PAGE_W    = 8,
  localparam int unsigned SUB_W    = ADDR_HI_W - PAGE_W,
  localparam int unsigned IO_BLOCKS = 1 << SUB_W
) (
  input logic [ADDR_HI_W-1:0] addr_hi,
  input logic                 rw,
  input logic                 phi2,
  input logic                 ram_cs_n,
  input logic                 rom_cs_n,
  input logic                 we_n,
  input logic                 ram_oe_n,
  input logic                 rom_oe_n,
  input logic [IO_BLOCKS-1:0] io_sel_n
);

  logic [PAGE_W-1:0] pg;
  logic              any_io;
  assign pg     = addr_hi[ADDR_HI_W-1:SUB_W];
  assign any_io = ~&io_sel_n;

  always_comb begin
    assert_low_ram_R1: assert (!(pg < PAGE_W'(8'hC0)) || !ram_cs_n)
      else $error("low page lost RAM select");
    assert_top_rom_R2: assert (!(pg == PAGE_W'(8'hFF)) || !rom_cs_n)
      else $error("top page lost ROM select");
    assert_one_region_R3: assert ($countones({~ram_cs_n, ~rom_cs_n, any_io}) == 1)
      else $error("region selects not exclusive");
    assert_we_phase_R4: assert (we_n || (phi2 && !rw))
      else $error("write enable outside write phase");
    assert_ram_oe_R5: assert (ram_oe_n || (phi2 && rw && !ram_cs_n))
      else $error("RAM output enable out of place");
    assert_rom_oe_write_R6: assert (rw || rom_oe_n)
      else $error("ROM driven during write");
    assert_io_onehot_R8: assert ($onehot0(~io_sel_n))
      else $error("more than one I/O block selected");
  end

endmodule

bind mem_glue_decoder glue_decoder_chk #(
  .ADDR_HI_W(ADDR_HI_W),
  .PAGE_W   (PAGE_W)
) u_chk (.*);

// File: tb/tb_mem_glue_decoder.sv
module tb_mem_glue_decoder;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic [10:0] addr_hi = '0;
  logic        rw = 1'b1;
  logic        phi2 = 1'b0;
  logic        ram_cs_n, rom_cs_n, we_n, ram_oe_n, rom_oe_n;
  logic [7:0]  io_sel_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_glue_decoder dut (
    .addr_hi (addr_hi),
    .rw      (rw),
    .phi2    (phi2),
    .ram_cs_n(ram_cs_n),
    .rom_cs_n(rom_cs_n),
    .we_n    (we_n),
    .ram_oe_n(ram_oe_n),
    .rom_oe_n(rom_oe_n),
    .io_sel_n(io_sel_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s addr_hi=%h phi2=%b rw=%b actual=%h expected=%h",
               tag, addr_hi, phi2, rw, act, exp);
    end
  endtask

  // Behavioural reference, compared every clock.
  task automatic apply(input int hb, input int sub, input bit ph, input bit r);
    bit e_ram, e_rom, e_io;
    logic [7:0] e_sel;
    @(posedge clk);
    #1;
    addr_hi = {8'(hb), 3'(sub)};
    phi2 = ph;
    rw = r;
    @(negedge clk);
    e_io  = (hb == 254);
    e_ram = (hb <= 191);
    e_rom = !e_ram && !e_io;
    e_sel = e_io ? ~(8'd1 << sub) : 8'hFF;
    chk(ram_cs_n == !e_ram, "R1/R7 ram_cs_n", {7'd0, ram_cs_n}, {7'd0, !e_ram});
    chk(rom_cs_n == !e_rom, "R2/R7 rom_cs_n", {7'd0, rom_cs_n}, {7'd0, !e_rom});
    chk(((!ram_cs_n) + (!rom_cs_n) + (io_sel_n != 8'hFF)) == 1, "R3 one region",
        {5'd0, !ram_cs_n, !rom_cs_n, io_sel_n != 8'hFF}, 8'd1);
    chk(we_n == !(ph && !r), "R4 we_n", {7'd0, we_n}, {7'd0, !(ph && !r)});
    chk(ram_oe_n == !(ph && r && e_ram), "R5 ram_oe_n", {7'd0, ram_oe_n}, {7'd0, !(ph && r && e_ram)});
    chk(rom_oe_n == !(ph && r && e_rom), "R6 rom_oe_n", {7'd0, rom_oe_n}, {7'd0, !(ph && r && e_rom)});
    chk(io_sel_n == e_sel, "R8 io_sel_n", io_sel_n, e_sel);
  endtask

  initial begin
    // Idle state: clock low, read, address 0 -> only RAM selected, strobes high.
    @(negedge clk);
    chk(we_n && ram_oe_n && rom_oe_n, "R4 idle strobes", {5'd0, we_n, ram_oe_n, rom_oe_n}, 8'h07);
    chk(!ram_cs_n && rom_cs_n && io_sel_n == 8'hFF, "R1 idle selects", {7'd0, ram_cs_n}, 8'h00);

    // Directed boundaries.
    apply(191, 7, 1, 1);  // R1 last RAM page, read
    apply(192, 0, 1, 1);  // R2 first ROM page
    apply(253, 7, 1, 0);  // R6 ROM write keeps rom_oe_n high
    apply(254, 0, 1, 1);  // R3 I/O page
    apply(254, 7, 0, 0);  // R8 last block, R7 clock low
    apply(255, 0, 1, 1);  // R2 vector page in ROM
    apply(255, 3, 1, 0);  // R6 vector page write

    // Full sweep: every page, every block code, every phase/direction.
    for (int hb = 0; hb < 256; hb++)
      for (int sub = 0; sub < 8; sub++)
        for (int m = 0; m < 4; m++)
          apply(hb, sub, m[1], m[0]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule